// File: doc/BRIEF.md
# Period-match timer with match postscaler

This block is an 8-bit up-counter that advances on a qualified tick. The tick input stands for the system clock divided by four. A selectable prescaler of 1, 4 or 16 sits in front of the counter. The counter is compared with an 8-bit period value. When the two are equal at a qualified count, the counter returns to zero and a one-clock unscaled match pulse is exported. That pulse is meant to drive a PWM time base or a serial shift clock elsewhere in the chip.

The same match events feed a 4-bit postscaler. After a programmable number of matches, from 1 to 16, it sets a sticky flag. An interrupt output follows the flag whenever an external enable pin is high.

Software reaches the control, counter and period values through a plain register port. Writes are accepted in every cycle in which `reg_we` is high, so the port has no back-pressure and no valid/ready handshake. Reads are combinational from the addressed register.

Top module: `match_timer`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the period reads 8'hFF, and `match_o`, `flag_o` and `irq_o` are low.
- R2: While control bit 0 (run) is clear, the counter holds its value whatever `tick_en` does.
- R3: Control bits [2:1] select the prescale ratio: 2'b00 divides by 1, 2'b01 divides by 4, and 2'b10 or 2'b11 divide by 16. The counter advances once per that many cycles in which `tick_en` is high and run is set.
- R4: The counter counts up from 0. When a prescaled count arrives while the counter equals the period, the counter becomes 0 at that edge. `match_o` is high for exactly the clock cycle that follows that edge.
- R5: Control bits [6:3] hold a postscale value S. `flag_o` is set on the (S+1)th match since the postscaler was last cleared, in the same cycle as that match's `match_o`.
- R6: `flag_o` stays set until a cycle with `flag_clr` high. When a set and `flag_clr` occur in the same cycle, the flag ends up set.
- R7: `irq_o` is high exactly when `flag_o` and `irq_en` are both high.
- R8: A write to the counter (address 1) or to the control register (address 0) clears the prescaler and postscaler counts. No count happens in that cycle, and the period is not changed.
- R9: Writing the period does not disturb the counter or the partial counts. If the counter is already above the period, it runs on through 8'hFF and wraps to 0 with no match.
- R10: Register map on the 2-bit address: 0 control, with bit 7 reading 0; 1 counter; 2 period; 3 reads 0 and ignores writes. A written value reads back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count qualifier (system clock divided by four) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data of the addressed register |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the sticky flag |
| match_o | output | 1 | Unscaled one-cycle match pulse |
| flag_o | output | 1 | Sticky postscaled match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register write, the counter step, `match_o` and `flag_o` settle at the single clock edge after the cycle in which the stimulus is presented. `irq_o` and `reg_rdata` follow their inputs combinationally. The bench drives inputs on the falling edge and advances a cycle-level reference model by one step. At the next falling edge it compares every output and the addressed register, so each result is checked in exactly the cycle it is due. The model is exercised by directed phases for each prescale ratio, the hold, the set-versus-clear case and period rewrites. These are followed by seeded random traffic.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int CNT_W     = 8;
  localparam int POST_W    = 4;
  localparam int PRE_SEL_W = 2;
  localparam int PRE_STEP  = 2;  // log2 of the ratio step (x4)
  localparam int PRE_STEPS = 2;  // ratios 1, 4, 16
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_PERIOD = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic                 rsvd;
    logic [POST_W-1:0]    post_sel;
    logic [PRE_SEL_W-1:0] pre_sel;
    logic                 run;
  } ctrl_t;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int SEL_W = 2,
  parameter int STEP  = 2,
  parameter int STEPS = 2,
  localparam int CW   = STEP * STEPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  // ratio = 2^(STEP*min(sel,STEPS)); last = ratio-1
  always_comb begin
    last = '0;
    for (int k = 1; k <= STEPS; k++) begin
      if (int'(sel) >= k) last = CW'((1 << (STEP * k)) - 1);
    end
  end

  assign pulse = run && tick_en && !clear && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (run && tick_en) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  // R8
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         hit,
  output logic         match_q
);
  assign hit = step && (count == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit;
      if (load)      count <= load_val;
      else if (step) count <= hit ? '0 : count + 1'b1;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> count == '0);
  // R9
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit && !load) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/mt_postscaler.sv
module mt_postscaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         hit,
  input  logic [W-1:0] sel,
  input  logic         flag_clr,
  output logic         flag
);
  logic [W-1:0] cnt_q;
  logic         set;

  assign set = hit && (cnt_q == sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (clear)    cnt_q <= '0;
      else if (hit) cnt_q <= set ? '0 : cnt_q + 1'b1;
      if (set)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  // R5
  post_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= sel);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set && flag_clr) |=> flag);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CW = mt_pkg::CNT_W,
  parameter int AW = mt_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          match_o,
  output logic          flag_o,
  output logic          irq_o
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] period_q;
  logic [CW-1:0] count;
  logic          wr_ctrl, wr_count, wr_period, clr_parts;
  logic          pre_pulse, hit;
  reg_sel_e      sel;

  assign sel       = reg_sel_e'(reg_addr);
  assign wr_ctrl   = reg_we && (sel == REG_CTRL);
  assign wr_count  = reg_we && (sel == REG_COUNT);
  assign wr_period = reg_we && (sel == REG_PERIOD);
  assign clr_parts = wr_ctrl || wr_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_t'({1'b0, reg_wdata[6:0]});
      if (wr_period) period_q <= reg_wdata;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:   reg_rdata = CW'(ctrl_q);
      REG_COUNT:  reg_rdata = count;
      REG_PERIOD: reg_rdata = period_q;
      default:    reg_rdata = '0;
    endcase
  end

  mt_prescaler #(
    .SEL_W(PRE_SEL_W), .STEP(PRE_STEP), .STEPS(PRE_STEPS)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(clr_parts), .run(ctrl_q.run),
    .tick_en(tick_en), .sel(ctrl_q.pre_sel), .pulse(pre_pulse)
  );

  mt_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .step(pre_pulse),
    .load(wr_count), .load_val(reg_wdata), .period(period_q),
    .count(count), .hit(hit), .match_q(match_o)
  );

  mt_postscaler #(.W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(clr_parts), .hit(hit),
    .sel(ctrl_q.post_sel), .flag_clr(flag_clr), .flag(flag_o)
  );

  assign irq_o = flag_o && irq_en;

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> match_o);
  // R8
  period_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel != REG_PERIOD) |=> $stable(period_q));
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
endmodule

// File: tb/test_match_timer.sv
module test_match_timer;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, reg_we, irq_en, flag_clr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       match_o, flag_o, irq_o;

  always #5 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_en(irq_en), .flag_clr(flag_clr), .match_o(match_o),
    .flag_o(flag_o), .irq_o(irq_o)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_tag = "R1";
  bit    ien_g = 0;

  // reference model state
  bit       m_run;
  bit [1:0] m_psel;
  bit [3:0] m_osel;
  bit [7:0] m_cnt, m_per;
  bit [3:0] m_pre;
  bit [3:0] m_post;
  bit       m_flag, m_match;

  function automatic bit [7:0] mk_ctrl(bit run, bit [1:0] ps, bit [3:0] os);
    return {1'b0, os, ps, run};
  endfunction

  function automatic bit [7:0] exp_read(bit [1:0] a);
    case (a)
      2'd0:    return mk_ctrl(m_run, m_psel, m_osel);
      2'd1:    return m_cnt;
      2'd2:    return m_per;
      default: return 8'd0;
    endcase
  endfunction

  function automatic bit [3:0] ratio_last(bit [1:0] ps);
    // R3: 00 -> /1, 01 -> /4, 1x -> /16
    if (ps == 2'b00) return 4'd0;
    if (ps == 2'b01) return 4'd3;
    return 4'd15;
  endfunction

  function automatic void model_reset();
    m_run = 0; m_psel = 0; m_osel = 0; m_cnt = 0; m_per = 8'hFF;
    m_pre = 0; m_post = 0; m_flag = 0; m_match = 0;
  endfunction

  function automatic void model_step(bit tk, bit we, bit [1:0] a, bit [7:0] wd, bit clr);
    bit wclr, ptick, hit, set;
    bit [3:0] lim;
    wclr  = we && (a == 2'd0 || a == 2'd1);
    lim   = ratio_last(m_psel);
    ptick = m_run && tk && !wclr && (m_pre == lim);
    hit   = ptick && (m_cnt == m_per);
    set   = hit && (m_post == m_osel);
    if (wclr) m_pre = 0;
    else if (m_run && tk) m_pre = (m_pre == lim) ? 4'd0 : m_pre + 4'd1;
    if (wclr) m_post = 0;
    else if (hit) m_post = set ? 4'd0 : m_post + 4'd1;
    if (we && a == 2'd1) m_cnt = wd;
    else if (ptick) m_cnt = hit ? 8'd0 : m_cnt + 8'd1;
    if (set) m_flag = 1;
    else if (clr) m_flag = 0;
    m_match = hit;
    if (we && a == 2'd0) begin
      m_run = wd[0]; m_psel = wd[2:1]; m_osel = wd[6:3];
    end
    if (we && a == 2'd2) m_per = wd;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(cur_tag, "match_o R4", 32'(match_o), 32'(m_match));
    chk(cur_tag, "flag_o R5", 32'(flag_o), 32'(m_flag));
    chk(cur_tag, "irq_o R7", 32'(irq_o), 32'(m_flag && irq_en));
    chk(cur_tag, "reg_rdata R10", 32'(reg_rdata), 32'(exp_read(reg_addr)));
  endtask

  task automatic cyc(bit tk, bit we, bit [1:0] a, bit [7:0] wd, bit clr, bit ien, string tag);
    @(negedge clk);
    compare();
    tick_en = tk; reg_we = we; reg_addr = a; reg_wdata = wd;
    flag_clr = clr; irq_en = ien;
    model_step(tk, we, a, wd, clr);
    cur_tag = tag;
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d, string tag);
    cyc(1'b0, 1'b1, a, d, 1'b0, ien_g, tag);
  endtask

  task automatic run(int n, int tkper, bit [1:0] a, bit clr, string tag);
    for (int i = 0; i < n; i++) cyc((i % tkper) == 0, 1'b0, a, 8'd0, clr, ien_g, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; tick_en = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    irq_en = 0; flag_clr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset values on every address
    for (int a = 0; a < 4; a++) cyc(1'b0, 1'b0, 2'(a), 8'd0, 1'b0, 1'b0, "R1");
    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R1");

    // R2: run clear, counter holds under ticks
    wr(2'd2, 8'd10, "R2");
    wr(2'd1, 8'd3, "R2");
    wr(2'd0, mk_ctrl(1'b0, 2'b00, 4'd0), "R2");
    run(20, 1, 2'd1, 1'b0, "R2");

    // R3: each prescale encoding
    for (int ps = 0; ps < 4; ps++) begin
      wr(2'd0, mk_ctrl(1'b1, 2'(ps), 4'd0), "R3");
      run(ps == 0 ? 40 : (ps == 1 ? 80 : 200), 1, 2'd1, 1'b0, "R3");
    end

    // R4/R5/R7: /4 tick, postscale 3 matches
    ien_g = 1;
    wr(2'd2, 8'd3, "R5");
    wr(2'd0, mk_ctrl(1'b1, 2'b00, 4'd2), "R5");
    run(300, 4, 2'd1, 1'b0, "R5");
    ien_g = 0;
    run(20, 4, 2'd1, 1'b0, "R7");

    // R6: clear held high, set must still win
    wr(2'd2, 8'd2, "R6");
    wr(2'd0, mk_ctrl(1'b1, 2'b00, 4'd0), "R6");
    run(60, 1, 2'd0, 1'b1, "R6");

    // R8: counter and control rewrites mid-count
    wr(2'd0, mk_ctrl(1'b1, 2'b01, 4'd1), "R8");
    for (int k = 0; k < 10; k++) begin
      run(7, 1, 2'd1, 1'b0, "R8");
      wr(2'd1, 8'(k), "R8");
      run(5, 1, 2'd2, 1'b0, "R8");
      wr(2'd0, mk_ctrl(1'b1, 2'b01, 4'd1), "R8");
    end

    // R9: period dropped below the counter
    wr(2'd0, mk_ctrl(1'b1, 2'b00, 4'd0), "R9");
    wr(2'd2, 8'd200, "R9");
    wr(2'd1, 8'd140, "R9");
    run(10, 1, 2'd1, 1'b0, "R9");
    wr(2'd2, 8'd50, "R9");
    run(300, 1, 2'd1, 1'b0, "R9");

    // R10 and all: seeded random traffic
    for (int i = 0; i < 20000; i++) begin
      bit       tk, we, clr;
      bit [1:0] a;
      bit [7:0] wd;
      tk  = ($urandom % 3) == 0;
      we  = ($urandom % 24) == 0;
      a   = 2'($urandom % 4);
      wd  = 8'($urandom);
      if (a == 2'd2) wd = 8'($urandom % 9);
      if (a == 2'd0) wd[0] = ($urandom % 8) != 0;
      clr = ($urandom % 10) == 0;
      if (($urandom % 50) == 0) ien_g = !ien_g;
      cyc(tk, we, a, wd, clr, ien_g, "R10");
    end

    cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, "R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule